// File: doc/BRIEF.md
# In-Order Retire Queue with Variable-Length Records

This block keeps the program order of in-flight instructions in a circular array of slots and retires them in that order. Dispatch presents an instruction identifier and its micro-op count. If enough slots are free, the block writes a record at the current tail slot and returns that slot index as the instruction's token. The record holds the identifier, the number of slots it covers and an executed flag. The tail then moves past the record. Dispatch uses the free-slot count and the ready output to stall when the queue cannot take the request.

When execution of an instruction finishes, its token is presented on the execute port, and the record's executed flag is set on the next edge. In every cycle the block walks forward from the head slot. It retires each record whose flag is set and stops at the first record that has not executed, or when the queue becomes empty. Each retired record moves the head forward by its own length and gives those slots back. Retirements in one cycle can be limited by a parameter. A limit of zero allows as many as the queue holds. Retired identifiers appear on parallel lanes, oldest on lane 0.

Top module: `rq_top`

## Requirements
- R1: Synchronous active-high reset leaves the queue empty: the free count equals SLOTS, the token output is 0, and no retire lane is valid.
- R2: A record covers its micro-op count clamped to the range 1..SLOTS, so a count of 0 takes one slot and any count above SLOTS takes SLOTS slots.
- R3: The token offered to dispatch is the tail slot index. An accepted reservation moves the tail forward by the record length modulo SLOTS, and the free count drops by that length.
- R4: resvReady is 1 exactly when the free count is at least the clamped length of the request. A request with resvValid high and resvReady low leaves the token and the free count unchanged.
- R5: An execute-complete for a token sets that record's executed flag at the clock edge. The record can retire in the following cycle at the earliest.
- R6: Retirement is strictly in order. While the head record has not executed, nothing retires, even if younger records have executed.
- R7: A retiring record is reported on a lane with its identifier, with the oldest record on lane 0 and valid lanes contiguous from lane 0. The head moves forward by the record length and the free count rises by that length on the same edge.
- R8: At most MAX_RETIRE records retire in one cycle. With MAX_RETIRE = 0, every executed record in order at the head retires in that cycle.
- R9: In a cycle that has both a reservation and retirements, the next free count is the old count plus the retired lengths minus the reserved length. A record reserved in a cycle never retires in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resvValid | input | 1 | Dispatch requests a reservation |
| resvUops | input | UOPW | Micro-op count of the instruction being dispatched |
| resvId | input | IDW | Identifier of the instruction being dispatched |
| resvReady | output | 1 | Enough free slots for the present request |
| resvToken | output | clog2(SLOTS) | Tail slot index, returned as the token |
| execValid | input | 1 | Execute-complete strobe |
| execToken | input | clog2(SLOTS) | Token of the record that finished executing |
| retireValid | output | LANES | Per-lane retire valid, lane 0 oldest |
| retireId | output | LANES*IDW | Per-lane retired identifier, lane 0 in the low bits |
| freeSlots | output | clog2(SLOTS+1) | Number of free slots |

## Verification
The bench goes after the places where length arithmetic and ordering can go wrong. It sends a zero micro-op count, which a design that skips the lower clamp would record as an empty record, wedging the head. It sends an oversized count, which a design without the upper clamp would let wrap the tail or underflow the free count. It makes a tail advance cross the end of the array and a full-queue record start and end on the same index, which breaks modulo handling and any emptiness test based on pointers. Younger records are marked before the head record, which exposes out-of-order retirement. A rejected request comes before retirements, which exposes a tail that moves without acceptance. A cycle that both reserves and retires catches free-count updates that drop one side. A capped and an uncapped instance run side by side to check the retire limit and the meaning of zero.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Strobes from the control path to the record store.
  typedef struct packed {
    logic write;  // store a new record at the tail
    logic mark;   // set the executed flag of a record
  } rqStrobe_t;

endpackage

// File: rtl/rq_datapath.sv
module rq_datapath
  import rq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDW   = 8,
  parameter int CNTW  = 4,
  parameter int IDXW  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  rqStrobe_t                   stb,
  input  logic [IDXW-1:0]             wrIdx,
  input  logic [IDW-1:0]              wrId,
  input  logic [CNTW-1:0]             wrLen,
  input  logic [IDXW-1:0]             markIdx,
  input  logic [SLOTS-1:0]            clrMask,
  output logic [SLOTS-1:0][IDW-1:0]   idArr,
  output logic [SLOTS-1:0][CNTW-1:0]  lenArr,
  output logic [SLOTS-1:0]            doneArr
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hitWrite;
    logic hitMark;

    assign hitWrite = stb.write && (wrIdx == IDXW'(s));
    assign hitMark  = stb.mark && (markIdx == IDXW'(s));

    always_ff @(posedge clk) begin
      if (hitWrite) begin
        idArr[s]  <= wrId;
        lenArr[s] <= wrLen;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        doneArr[s] <= 1'b0;
      end else if (hitWrite) begin
        doneArr[s] <= 1'b0;
      end else if (hitMark) begin
        doneArr[s] <= 1'b1;
      end else if (clrMask[s]) begin
        doneArr[s] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rq_control.sv
module rq_control
  import rq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int LANES = 2,
  parameter int IDW   = 8,
  parameter int UOPW  = 4,
  parameter int CNTW  = 4,
  parameter int IDXW  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        resvValid,
  input  logic [UOPW-1:0]             resvUops,
  input  logic                        execValid,
  input  logic [IDXW-1:0]             execToken,
  input  logic [SLOTS-1:0][IDW-1:0]   idArr,
  input  logic [SLOTS-1:0][CNTW-1:0]  lenArr,
  input  logic [SLOTS-1:0]            doneArr,
  output rqStrobe_t                   stb,
  output logic [IDXW-1:0]             wrIdx,
  output logic [CNTW-1:0]             wrLen,
  output logic [IDXW-1:0]             markIdx,
  output logic [SLOTS-1:0]            clrMask,
  output logic [LANES-1:0]            retireValid,
  output logic [LANES-1:0][IDW-1:0]   laneId,
  output logic                        resvReady,
  output logic [IDXW-1:0]             resvToken,
  output logic [CNTW-1:0]             freeSlots
);

  localparam int SW = CNTW + 1;
  localparam int CW = (UOPW > CNTW) ? UOPW : CNTW;
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(SLOTS);

  logic [IDXW-1:0] headIdx;
  logic [IDXW-1:0] tailIdx;
  logic [CNTW-1:0] freeCnt;
  logic [IDXW-1:0] headEnd;
  logic [CNTW-1:0] freeEnd;
  logic [CNTW-1:0] need;
  logic            accept;

  function automatic logic [IDXW-1:0] wrapAdd(input logic [IDXW-1:0] p,
                                              input logic [CNTW-1:0] n);
    logic [SW-1:0] sum;
    sum = SW'(p) + SW'(n);
    if (sum >= SW'(SLOTS)) sum = sum - SW'(SLOTS);
    return IDXW'(sum);
  endfunction

  function automatic logic [CNTW-1:0] clampLen(input logic [UOPW-1:0] u);
    logic [CW-1:0] w;
    w = CW'(u);
    if (w == '0) return CNTW'(1);
    if (w > CW'(SLOTS)) return FULL_CNT;
    return CNTW'(w);
  endfunction

  assign need      = clampLen(resvUops);
  assign resvReady = (freeCnt >= need);
  assign accept    = resvValid && resvReady;
  assign resvToken = tailIdx;
  assign freeSlots = freeCnt;

  assign stb.write = accept;
  assign stb.mark  = execValid;
  assign wrIdx     = tailIdx;
  assign wrLen     = need;
  assign markIdx   = execToken;

  // Retire walk: one step per lane, each step starting where the last ended.
  always_comb begin
    logic [IDXW-1:0] h;
    logic [CNTW-1:0] f;
    logic            go;
    h           = headIdx;
    f           = freeCnt;
    go          = 1'b1;
    clrMask     = '0;
    retireValid = '0;
    laneId      = '0;
    for (int i = 0; i < LANES; i++) begin
      laneId[i] = idArr[h];
      if (go && (f != FULL_CNT) && doneArr[h]) begin
        retireValid[i] = 1'b1;
        clrMask[h]     = 1'b1;
        f              = f + lenArr[h];
        h              = wrapAdd(h, lenArr[h]);
      end else begin
        go = 1'b0;
      end
    end
    headEnd = h;
    freeEnd = f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headIdx <= '0;
      tailIdx <= '0;
      freeCnt <= FULL_CNT;
    end else begin
      headIdx <= headEnd;
      if (accept) tailIdx <= wrapAdd(tailIdx, need);
      freeCnt <= freeEnd - (accept ? need : '0);
    end
  end

endmodule

// File: rtl/rq_top.sv
module rq_top
  import rq_pkg::*;
#(
  parameter  int SLOTS      = 8,
  parameter  int MAX_RETIRE = 2,
  parameter  int IDW        = 8,
  parameter  int UOPW       = 4,
  localparam int LANES      = (MAX_RETIRE == 0 || MAX_RETIRE > SLOTS) ? SLOTS : MAX_RETIRE,
  localparam int IDXW       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNTW       = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  resvValid,
  input  logic [UOPW-1:0]       resvUops,
  input  logic [IDW-1:0]        resvId,
  output logic                  resvReady,
  output logic [IDXW-1:0]       resvToken,
  input  logic                  execValid,
  input  logic [IDXW-1:0]       execToken,
  output logic [LANES-1:0]      retireValid,
  output logic [LANES*IDW-1:0]  retireId,
  output logic [CNTW-1:0]       freeSlots
);

  rqStrobe_t                  stb;
  logic [IDXW-1:0]            wrIdx;
  logic [CNTW-1:0]            wrLen;
  logic [IDXW-1:0]            markIdx;
  logic [SLOTS-1:0]           clrMask;
  logic [SLOTS-1:0][IDW-1:0]  idArr;
  logic [SLOTS-1:0][CNTW-1:0] lenArr;
  logic [SLOTS-1:0]           doneFlags;
  logic [LANES-1:0][IDW-1:0]  laneId;

  rq_control #(
    .SLOTS(SLOTS), .LANES(LANES), .IDW(IDW),
    .UOPW(UOPW), .CNTW(CNTW), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .resvValid(resvValid), .resvUops(resvUops),
    .execValid(execValid), .execToken(execToken),
    .idArr(idArr), .lenArr(lenArr), .doneArr(doneFlags),
    .stb(stb), .wrIdx(wrIdx), .wrLen(wrLen), .markIdx(markIdx),
    .clrMask(clrMask), .retireValid(retireValid), .laneId(laneId),
    .resvReady(resvReady), .resvToken(resvToken), .freeSlots(freeSlots)
  );

  rq_datapath #(
    .SLOTS(SLOTS), .IDW(IDW), .CNTW(CNTW), .IDXW(IDXW)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .wrIdx(wrIdx), .wrId(resvId), .wrLen(wrLen),
    .markIdx(markIdx), .clrMask(clrMask),
    .idArr(idArr), .lenArr(lenArr), .doneArr(doneFlags)
  );

  assign retireId = laneId;

endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int SLOTS = 8,
  parameter int LANES = 2,
  parameter int UOPW  = 4,
  parameter int CNTW  = 4,
  parameter int IDXW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              resvValid,
  input logic [UOPW-1:0]   resvUops,
  input logic              resvReady,
  input logic              execValid,
  input logic [IDXW-1:0]   execToken,
  input logic [LANES-1:0]  retireValid,
  input logic [CNTW-1:0]   freeSlots,
  input logic [SLOTS-1:0]  doneFlags
);

  logic [CNTW-1:0] needC;

  always_comb begin
    if (resvUops == '0)                needC = CNTW'(1);
    else if (int'(resvUops) > SLOTS)   needC = CNTW'(SLOTS);
    else                               needC = CNTW'(resvUops);
  end

  // R1: the first cycle after reset shows an empty queue
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (freeSlots == CNTW'(SLOTS)));

  // R3: free count never exceeds the queue size
  p_free_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(freeSlots) <= SLOTS);

  // R3: an accepted reservation with no retirement lowers the free count by the clamped length
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (resvValid && resvReady && retireValid == '0) |=>
      (freeSlots == $past(freeSlots) - $past(needC)));

  // R5: a record is marked executed at most once
  p_single_mark_r5: assert property (@(posedge clk) disable iff (rst)
    execValid |-> !doneFlags[execToken]);

  // R7: valid lanes form a prefix starting at lane 0
  p_lane_prefix_r7: assert property (@(posedge clk) disable iff (rst)
    ((retireValid + LANES'(1)) & retireValid) == '0);

  // R6: an empty queue retires nothing
  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (freeSlots == CNTW'(SLOTS)) |-> (retireValid == '0));

endmodule

bind rq_top rq_checker #(
  .SLOTS(SLOTS), .LANES(LANES), .UOPW(UOPW), .CNTW(CNTW), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .resvValid(resvValid), .resvUops(resvUops),
  .resvReady(resvReady), .execValid(execValid), .execToken(execToken),
  .retireValid(retireValid), .freeSlots(freeSlots), .doneFlags(doneFlags)
);

// File: tb/tb_rq_top.sv
`timescale 1ns/1ps
module tb_rq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       resvValid = 1'b0;
  logic [3:0] resvUops = '0;
  logic [7:0] resvId = '0;
  logic       execValid = 1'b0;
  logic [2:0] execToken = '0;

  logic        rdyA, rdyB;
  logic [2:0]  tokA, tokB;
  logic [1:0]  rvA;
  logic [15:0] ridA;
  logic [7:0]  rvB;
  logic [63:0] ridB;
  logic [3:0]  freeA, freeB;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rq_top #(.SLOTS(8), .MAX_RETIRE(2), .IDW(8), .UOPW(4)) dut (
    .clk(clk), .rst(rst), .resvValid(resvValid), .resvUops(resvUops),
    .resvId(resvId), .resvReady(rdyA), .resvToken(tokA),
    .execValid(execValid), .execToken(execToken),
    .retireValid(rvA), .retireId(ridA), .freeSlots(freeA)
  );

  rq_top #(.SLOTS(8), .MAX_RETIRE(0), .IDW(8), .UOPW(4)) dutNoCap (
    .clk(clk), .rst(rst), .resvValid(resvValid), .resvUops(resvUops),
    .resvId(resvId), .resvReady(rdyB), .resvToken(tokB),
    .execValid(execValid), .execToken(execToken),
    .retireValid(rvB), .retireId(ridB), .freeSlots(freeB)
  );

  typedef struct packed {
    logic       rv;
    logic [3:0] uops;
    logic [7:0] id;
    logic       ev;
    logic [2:0] etok;
    logic [3:0] eFree;
    logic [2:0] eTok;
    logic       eRdy;
    logic [1:0] eRetN;
    logic [7:0] eRet0;
    logic [7:0] eRet1;
    logic [3:0] rq;
  } vec_t;

  // Inputs applied in a cycle, outputs expected in that same cycle (before its edge).
  localparam vec_t VECS [14] = '{
    '{1'b1, 4'd2,  8'h10, 1'b0, 3'd0, 4'd8, 3'd0, 1'b1, 2'd0, 8'h00, 8'h00, 4'd3}, // R3 first record at slot 0
    '{1'b1, 4'd0,  8'h11, 1'b0, 3'd0, 4'd6, 3'd2, 1'b1, 2'd0, 8'h00, 8'h00, 4'd2}, // R2 zero uops -> 1 slot
    '{1'b1, 4'd3,  8'h12, 1'b0, 3'd0, 4'd5, 3'd3, 1'b1, 2'd0, 8'h00, 8'h00, 4'd3}, // R3 tail 3
    '{1'b1, 4'd3,  8'h13, 1'b1, 3'd2, 4'd2, 3'd6, 1'b0, 2'd0, 8'h00, 8'h00, 4'd4}, // R4 no room; mark younger
    '{1'b0, 4'd0,  8'h00, 1'b1, 3'd3, 4'd2, 3'd6, 1'b1, 2'd0, 8'h00, 8'h00, 4'd4}, // R4 state unchanged; R6
    '{1'b0, 4'd0,  8'h00, 1'b1, 3'd0, 4'd2, 3'd6, 1'b1, 2'd0, 8'h00, 8'h00, 4'd6}, // R6 head not done
    '{1'b1, 4'd2,  8'h14, 1'b0, 3'd0, 4'd2, 3'd6, 1'b1, 2'd2, 8'h10, 8'h11, 4'd5}, // R5 R8 cap 2, tail wraps
    '{1'b1, 4'd15, 8'h15, 1'b0, 3'd0, 4'd3, 3'd0, 1'b0, 2'd1, 8'h12, 8'h00, 4'd9}, // R9 2+3-2; new rec waits
    '{1'b0, 4'd0,  8'h00, 1'b1, 3'd6, 4'd6, 3'd0, 1'b1, 2'd0, 8'h00, 8'h00, 4'd4}, // R4 R7 rejected, freed 3
    '{1'b0, 4'd0,  8'h00, 1'b0, 3'd0, 4'd6, 3'd0, 1'b1, 2'd1, 8'h14, 8'h00, 4'd7}, // R7 retire across wrap
    '{1'b1, 4'd15, 8'h15, 1'b0, 3'd0, 4'd8, 3'd0, 1'b1, 2'd0, 8'h00, 8'h00, 4'd2}, // R2 clamp to 8
    '{1'b1, 4'd1,  8'h16, 1'b1, 3'd0, 4'd0, 3'd0, 1'b0, 2'd0, 8'h00, 8'h00, 4'd4}, // R4 full queue
    '{1'b0, 4'd0,  8'h00, 1'b0, 3'd0, 4'd0, 3'd0, 1'b0, 2'd1, 8'h15, 8'h00, 4'd7}, // R7 full record retires
    '{1'b0, 4'd0,  8'h00, 1'b0, 3'd0, 4'd8, 3'd0, 1'b1, 2'd0, 8'h00, 8'h00, 4'd7}  // R7 all slots back
  };

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [3:0] u, input logic [7:0] id,
                       input logic ev, input logic [2:0] et);
    @(negedge clk);
    resvValid = rv; resvUops = u; resvId = id;
    execValid = ev; execToken = et;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    resvValid = 1'b0; execValid = 1'b0; resvUops = '0; resvId = '0; execToken = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    doReset();
    // R1 reset state on both instances
    chk("R1", "free", int'(freeA), 8);
    chk("R1", "token", int'(tokA), 0);
    chk("R1", "retire", int'(rvA), 0);
    chk("R1", "free nocap", int'(freeB), 8);

    for (int k = 0; k < 14; k++) begin
      vec_t v;
      string tag;
      v = VECS[k];
      tag = $sformatf("R%0d", v.rq);
      drive(v.rv, v.uops, v.id, v.ev, v.etok);
      chk(tag, $sformatf("row%0d free", k), int'(freeA), int'(v.eFree));
      chk(tag, $sformatf("row%0d token", k), int'(tokA), int'(v.eTok));
      chk(tag, $sformatf("row%0d ready", k), int'(rdyA), int'(v.eRdy));
      chk(tag, $sformatf("row%0d retired", k), $countones(rvA), int'(v.eRetN));
      if (v.eRetN > 0) chk(tag, $sformatf("row%0d lane0 id", k), int'(ridA[7:0]), int'(v.eRet0));
      if (v.eRetN > 1) chk(tag, $sformatf("row%0d lane1 id", k), int'(ridA[15:8]), int'(v.eRet1));
    end

    // R8: capped vs uncapped retirement of four executed one-slot records
    doReset();
    for (int j = 0; j < 4; j++) drive(1'b1, 4'd1, 8'(8'h20 + j), 1'b0, 3'd0);
    for (int j = 3; j >= 0; j--) drive(1'b0, 4'd0, 8'h00, 1'b1, 3'(j));
    drive(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
    chk("R8", "capped count", $countones(rvA), 2);
    chk("R8", "capped lane0", int'(ridA[7:0]), 8'h20);
    chk("R8", "capped lane1", int'(ridA[15:8]), 8'h21);
    chk("R8", "uncapped count", $countones(rvB), 4);
    for (int j = 0; j < 4; j++)
      chk("R8", $sformatf("uncapped lane%0d", j), int'(ridB[j*8 +: 8]), 8'h20 + j);
    drive(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
    chk("R8", "capped second batch", $countones(rvA), 2);
    chk("R8", "capped lane0 second", int'(ridA[7:0]), 8'h22);
    chk("R8", "uncapped empty", int'(freeB), 8);
    drive(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
    chk("R7", "capped drained", int'(freeA), 8);

    // R1: reset in the middle of activity
    drive(1'b1, 4'd5, 8'h30, 1'b0, 3'd0);
    drive(1'b0, 4'd0, 8'h00, 1'b0, 3'd0);
    chk("R3", "mid free", int'(freeA), 3);
    doReset();
    chk("R1", "free after reset", int'(freeA), 8);
    chk("R1", "token after reset", int'(tokA), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule